// File: doc/BRIEF.md
# Asynchronous serial receiver with latched error status

The block receives asynchronous serial frames on a single line and hands each received character to software through a small register port. The line is oversampled by a free-running enable `tick_i` at 16 times the bit rate, passed through a two-flop synchroniser, and watched for a low start bit. A start bit is confirmed at its centre. Each later bit (data LSB first, an optional parity bit and one or two stop bits) is sampled at its centre.

When a frame completes, the receiver judges it. It checks the parity, the first stop bit and whether the previous character is still waiting in the data register. A clean frame stores the character and raises the full flag. A frame with a bad stop bit or a parity mismatch still stores the character, but it raises the matching error flag instead. A frame that ends while the full flag is still set raises the overrun flag and leaves the data register untouched. Any raised error flag holds the receiver idle until software clears it.

Software sets the frame format and the interrupt enable through the control register. It reads the character from the data register and clears status flags by writing zeros. Two level interrupt outputs report a waiting character and a latched error.

Top module: `uart_rx_err`

## Requirements
- R1: After reset the control, status and data registers read 0 and both interrupt outputs are 0.
- R2: Data bits are assembled LSB first. With 8-bit format (control bit 1 = 0) the data register (address 2) holds all 8 bits. With 7-bit format (control bit 1 = 1) it holds the 7 received bits with bit 7 read as 0.
- R3: A start bit that has returned high at its centre sample is dropped, and no status or data change follows.
- R4: With parity enabled (control bit 2 = 1), the parity bit is checked against control bit 3 (0 = even count of ones over data plus parity, 1 = odd). A mismatch sets the parity flag (status bit 3) and stores the character, and the full flag keeps its previous value.
- R5: A first stop bit sampled low sets the framing flag (status bit 2) and stores the character, and the full flag keeps its previous value. With two stop bits (control bit 4 = 1) the second stop bit is never checked.
- R6: A frame that completes while the full flag (status bit 0) is 1 sets the overrun flag (status bit 1). The data register and the full flag are left unchanged.
- R7: A frame with no error sets the full flag and stores the character.
- R8: While any of status bits 1..3 is set, incoming frames are ignored. Reception resumes once all of them are cleared.
- R9: Writing the status register (address 1) clears each flag whose written bit is 0, and a written 1 leaves the flag as it was. Reading the data register does not clear the full flag.
- R10: `irq_rx_o` is 1 exactly while the enable (control bit 0) and the full flag are both 1. `irq_err_o` is 1 exactly while the enable and any of status bits 1..3 are 1.
- R11: The frame format is captured when the start bit is detected, so a control write during a frame does not alter how that frame is decoded.
- R12: When a frame completes in the same cycle as a status write, the flags raised by the frame survive the write. The overrun decision uses the full flag as it stood before the write.
- R13: The control register (address 0) reads back bits 4..0 as last written, with the upper bits 0. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversample enable, 16 per bit time |
| rx_i | input | 1 | Serial receive line, idle high |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 control, 1 status, 2 data |
| reg_wdata_i | input | DW (8) | Register write data |
| reg_rdata_o | output | DW (8) | Register read data, combinational on address |
| irq_rx_o | output | 1 | Character-waiting interrupt level |
| irq_err_o | output | 1 | Receive-error interrupt level |

## Verification
The collision that matters is a frame completing in the very cycle that software writes the status register. The bench aligns a clearing write onto the completion edge of a clean frame, and again onto a frame that finds the full flag already set. It judges the result against the rule that flags raised by the frame survive, and that overrun follows the pre-write full flag. A second overlap, a control write landing mid-frame, is judged by whether the character still decodes in the format captured at its start bit.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int NFLAGS = 4;
  localparam int CFG_W  = 5;

  // status bit positions
  localparam int FL_FULL = 0;
  localparam int FL_OVR  = 1;
  localparam int FL_FRM  = 2;
  localparam int FL_PAR  = 3;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  typedef struct packed {
    logic stop2;
    logic par_odd;
    logic par_en;
    logic len7;
    logic irq_en;
  } rx_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_STOP2
  } rx_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q[i] <= 1'b1;
        else if (i == 0) ff_q[i] <= d_i;
        else ff_q[i] <= ff_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/rx_frame.sv
module rx_frame
  import uart_rx_pkg::*;
#(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          block_i,
  input  rx_cfg_t       cfg_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] byte_o,
  output logic          fe_o,
  output logic          pe_o
);
  localparam int CW = $clog2(OVS);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sr_q;
  logic          par_q;
  logic          stop_bad_q;
  rx_cfg_t       cfg_q;

  logic [BW-1:0] last_bit;
  logic [DW-1:0] byte_n;
  logic          pe_n;

  assign last_bit = cfg_q.len7 ? BW'(DW-2) : BW'(DW-1);
  assign byte_n   = cfg_q.len7 ? {1'b0, sr_q[DW-1:1]} : sr_q;
  assign pe_n     = cfg_q.par_en && (par_q != cfg_q.par_odd);
  assign busy_o   = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      cnt_q      <= '0;
      bit_q      <= '0;
      sr_q       <= '0;
      par_q      <= 1'b0;
      stop_bad_q <= 1'b0;
      cfg_q      <= '0;
      done_o     <= 1'b0;
      byte_o     <= '0;
      fe_o       <= 1'b0;
      pe_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            if (!block_i && !rx_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
              cfg_q   <= cfg_i;  // format frozen for this frame
            end
          end
          ST_START: begin
            if (cnt_q == MID) begin
              cnt_q   <= '0;
              bit_q   <= '0;
              par_q   <= 1'b0;
              state_q <= rx_i ? ST_IDLE : ST_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sr_q  <= {rx_i, sr_q[DW-1:1]};
              par_q <= par_q ^ rx_i;
              bit_q <= bit_q + 1'b1;
              if (bit_q == last_bit) state_q <= cfg_q.par_en ? ST_PAR : ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              par_q   <= par_q ^ rx_i;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q      <= '0;
              stop_bad_q <= !rx_i;
              if (cfg_q.stop2) state_q <= ST_STOP2;
              else begin
                state_q <= ST_IDLE;
                done_o  <= 1'b1;
                byte_o  <= byte_n;
                fe_o    <= !rx_i;
                pe_o    <= pe_n;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
          ST_STOP2: begin
            // second stop bit timed but not judged
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
              done_o  <= 1'b1;
              byte_o  <= byte_n;
              fe_o    <= stop_bad_q;
              pe_o    <= pe_n;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/rx_regs.sv
module rx_regs
  import uart_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  input  logic              done_i,
  input  logic [DW-1:0]     byte_i,
  input  logic              fe_i,
  input  logic              pe_i,
  output rx_cfg_t           cfg_o,
  output logic [NFLAGS-1:0] flags_o,
  output logic [DW-1:0]     data_o,
  output logic              err_any_o,
  output logic              irq_rx_o,
  output logic              irq_err_o
);
  logic [NFLAGS-1:0] keep_mask, set_vec;
  logic              ovr;

  assign ovr = flags_o[FL_FULL];

  always_comb begin
    keep_mask = '1;
    if (we_i && addr_i == A_STAT) keep_mask = wdata_i[NFLAGS-1:0];
    set_vec = '0;
    if (done_i) begin
      set_vec[FL_OVR]  = ovr;
      set_vec[FL_FRM]  = fe_i;
      set_vec[FL_PAR]  = pe_i;
      set_vec[FL_FULL] = !(ovr || fe_i || pe_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_o <= '0;
      data_o  <= '0;
      cfg_o   <= '0;
    end else begin
      flags_o <= (flags_o & keep_mask) | set_vec;  // set wins over clear
      if (done_i && !ovr) data_o <= byte_i;
      if (we_i && addr_i == A_CTRL) cfg_o <= rx_cfg_t'(wdata_i[CFG_W-1:0]);
    end
  end

  always_comb begin
    case (addr_i)
      A_CTRL:  rdata_o = DW'(cfg_o);
      A_STAT:  rdata_o = DW'(flags_o);
      A_DATA:  rdata_o = data_o;
      default: rdata_o = '0;
    endcase
  end

  assign err_any_o = flags_o[FL_OVR] | flags_o[FL_FRM] | flags_o[FL_PAR];
  assign irq_rx_o  = cfg_o.irq_en & flags_o[FL_FULL];
  assign irq_err_o = cfg_o.irq_en & err_any_o;
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DW        = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  output logic          irq_rx_o,
  output logic          irq_err_o
);
  logic              rx_s;
  logic              frm_busy, frm_done, frm_fe, frm_pe;
  logic [DW-1:0]     frm_byte;
  rx_cfg_t           cfg;
  logic [NFLAGS-1:0] flags;
  logic [DW-1:0]     data;
  logic              err_any;
  logic              rx_block;

  // done pulse also blocks: its flags land one cycle later
  assign rx_block = err_any | frm_done;

  rx_sync #(.STAGES(SYNC_STGS)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  rx_frame #(.OVS(OVS), .DW(DW)) u_frame (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .rx_i   (rx_s),
    .block_i(rx_block),
    .cfg_i  (cfg),
    .busy_o (frm_busy),
    .done_o (frm_done),
    .byte_o (frm_byte),
    .fe_o   (frm_fe),
    .pe_o   (frm_pe)
  );

  rx_regs #(.DW(DW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (reg_we_i),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i),
    .rdata_o  (reg_rdata_o),
    .done_i   (frm_done),
    .byte_i   (frm_byte),
    .fe_i     (frm_fe),
    .pe_i     (frm_pe),
    .cfg_o    (cfg),
    .flags_o  (flags),
    .data_o   (data),
    .err_any_o(err_any),
    .irq_rx_o (irq_rx_o),
    .irq_err_o(irq_err_o)
  );
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk #(
  parameter int DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          done,
  input logic [DW-1:0] frm_byte,
  input logic          frm_fe,
  input logic          frm_pe,
  input logic [3:0]    flags,
  input logic [DW-1:0] data,
  input logic          busy,
  input logic          we,
  input logic [1:0]    addr,
  input logic [DW-1:0] wdata
);
  logic stat_wr;
  assign stat_wr = we && addr == 2'd1;

  p_ovr_keeps_data_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && flags[0] |=> $stable(data));

  p_ovr_sets_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && flags[0] |=> flags[1]);

  p_clean_sets_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !flags[0] && !frm_fe && !frm_pe |=> flags[0]);

  p_err_stores_byte_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !flags[0] && (frm_fe || frm_pe) |=> data == $past(frm_byte));

  p_err_keeps_full_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && (frm_fe || frm_pe) && !stat_wr |=> flags[0] == $past(flags[0]));

  p_blocked_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|flags[3:1]) && !busy |=> !busy);

  p_w1_no_effect_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr && wdata[3:0] == 4'hF && !done |=> $stable(flags));
endmodule

bind uart_rx_err uart_rx_err_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .done    (frm_done),
  .frm_byte(frm_byte),
  .frm_fe  (frm_fe),
  .frm_pe  (frm_pe),
  .flags   (flags),
  .data    (data),
  .busy    (frm_busy),
  .we      (reg_we_i),
  .addr    (reg_addr_i),
  .wdata   (reg_wdata_i)
);

// File: tb/tb_uart_rx_err.sv
`timescale 1ns/1ps
module tb_uart_rx_err;
  logic       clk, rst_ni, tick, rx;
  logic       we;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq_rx, irq_err;

  int checks = 0, fails = 0;
  bit finished = 0;
  string cur_req = "R1";

  uart_rx_err dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .rx_i(rx),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  // ---------------- reference model ----------------
  int         cyc;
  logic [4:0] m_cfg;
  logic [3:0] m_flags;
  logic [7:0] m_data;
  bit         cand_v, pend_v;
  int         cand_acc, cand_fin, pend_at;
  logic [7:0] cand_byte, pend_byte;
  bit         cand_fe, cand_pe, pend_fe, pend_pe;
  int         last_fin;

  always @(posedge clk) begin
    logic [3:0] setv, keep;
    bit ovr;
    int e;
    if (!rst_ni) begin
      cyc = 0; m_cfg = 0; m_flags = 0; m_data = 0; cand_v = 0; pend_v = 0;
    end else begin
      e = cyc + 1;
      if (cand_v && e == cand_acc) begin
        if (m_flags[3:1] == 0) begin
          pend_v = 1; pend_at = cand_fin; pend_byte = cand_byte;
          pend_fe = cand_fe; pend_pe = cand_pe;
        end
        cand_v = 0;
      end
      setv = 0;
      if (pend_v && e == pend_at) begin
        ovr = m_flags[0];
        setv = {pend_pe, pend_fe, ovr, !(ovr || pend_fe || pend_pe)};
        if (!ovr) m_data = pend_byte;
        pend_v = 0;
      end
      keep = (we && addr == 2'd1) ? wdata[3:0] : 4'hF;
      if (we && addr == 2'd0) m_cfg = wdata[4:0];
      m_flags = (m_flags & keep) | setv;
      cyc = e;
    end
  end

  function automatic logic [7:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0: return {3'b0, m_cfg};
      2'd1: return {4'b0, m_flags};
      2'd2: return m_data;
      default: return 8'h00;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    #2;
    if (rst_ni && !finished) begin
      checks++;
      if (rdata !== exp_rd(addr) || irq_rx !== (m_cfg[0] & m_flags[0]) ||
          irq_err !== (m_cfg[0] & |m_flags[3:1])) begin
        fails++;
        $display("FAIL %s cycle=%0d rdata=%h irq=%b%b exp rdata=%h irq=%b%b", cur_req, cyc,
                 rdata, irq_rx, irq_err, exp_rd(addr), m_cfg[0] & m_flags[0],
                 m_cfg[0] & |m_flags[3:1]);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    we = 1; addr = a; wdata = d;
    @(negedge clk);
    we = 0; addr = 2'd1; wdata = 0;
  endtask

  task automatic rd_chk(logic [1:0] a, logic [7:0] exp, string tag);
    addr = a;
    #2 chk(tag, rdata, exp);
    @(negedge clk);
    addr = 2'd1;
  endtask

  task automatic hold_bit(logic b);
    rx = b;
    repeat (16) @(negedge clk);
  endtask

  // cfg: {stop2, odd, par_en, len7}
  task automatic send_frame(logic [7:0] b, bit len7, bit pen, bit odd, bit st2,
                            bit bad_par, bit stop1, bit stop2v);
    int n;
    bit p;
    n = len7 ? 7 : 8;
    p = 0;
    for (int i = 0; i < n; i++) p ^= b[i];
    if (odd) p = ~p;
    if (bad_par) p = ~p;
    cand_byte = len7 ? {1'b0, b[6:0]} : b;
    cand_fe   = !stop1;
    cand_pe   = pen && bad_par;
    cand_acc  = cyc + 3;
    cand_fin  = cyc + 1 + 27 + 16 * (n + (pen ? 1 : 0) + (st2 ? 1 : 0));
    last_fin  = cand_fin;
    cand_v    = 1;
    hold_bit(1'b0);
    for (int i = 0; i < n; i++) hold_bit(b[i]);
    if (pen) hold_bit(p);
    hold_bit(stop1);
    if (st2) hold_bit(stop2v);
    rx = 1;
    repeat (24) @(negedge clk);
  endtask

  task automatic send_glitch();
    rx = 0;
    repeat (4) @(negedge clk);
    rx = 1;
    repeat (40) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(20 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_ni = 0; tick = 1; rx = 1; we = 0; addr = 2'd1; wdata = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    cur_req = "R1";
    rd_chk(2'd0, 8'h00, "R1 ctrl");
    rd_chk(2'd1, 8'h00, "R1 stat");
    rd_chk(2'd2, 8'h00, "R1 data");
    chk("R1 irqs", {6'b0, irq_rx, irq_err}, 8'h00);

    cur_req = "R13";
    wr(2'd0, 8'hE1);
    rd_chk(2'd0, 8'h01, "R13 ctrl readback");
    rd_chk(2'd3, 8'h00, "R13 addr3");

    cur_req = "R7";
    send_frame(8'hA5, 0, 0, 0, 0, 0, 1, 1);
    rd_chk(2'd1, 8'h01, "R7 full set");
    rd_chk(2'd2, 8'hA5, "R2 8-bit LSB first");
    chk("R10 irq_rx", {7'b0, irq_rx}, 8'h01);

    cur_req = "R9";
    rd_chk(2'd2, 8'hA5, "R9 reread");
    rd_chk(2'd1, 8'h01, "R9 read keeps full");
    wr(2'd1, 8'hFF);
    rd_chk(2'd1, 8'h01, "R9 write 1 no effect");
    wr(2'd1, 8'hFE);
    rd_chk(2'd1, 8'h00, "R9 write 0 clears");

    cur_req = "R2";
    wr(2'd0, 8'h03);
    send_frame(8'hD3, 1, 0, 0, 0, 0, 1, 1);
    rd_chk(2'd2, 8'h53, "R2 7-bit");
    wr(2'd1, 8'h00);

    cur_req = "R3";
    send_glitch();
    rd_chk(2'd1, 8'h00, "R3 glitch stat");
    rd_chk(2'd2, 8'h53, "R3 glitch data");

    cur_req = "R4";
    wr(2'd0, 8'h05);
    send_frame(8'h3C, 0, 1, 0, 0, 0, 1, 1);
    rd_chk(2'd1, 8'h01, "R4 even ok");
    wr(2'd1, 8'h00);
    send_frame(8'h81, 0, 1, 0, 0, 1, 1, 1);
    rd_chk(2'd1, 8'h08, "R4 parity flag");
    rd_chk(2'd2, 8'h81, "R4 data stored");
    chk("R10 irq on error", {6'b0, irq_rx, irq_err}, 8'h01);

    cur_req = "R8";
    send_frame(8'h11, 0, 1, 0, 0, 0, 1, 1);
    rd_chk(2'd1, 8'h08, "R8 blocked stat");
    rd_chk(2'd2, 8'h81, "R8 blocked data");
    wr(2'd1, 8'h07);
    send_frame(8'h22, 0, 1, 0, 0, 0, 1, 1);
    rd_chk(2'd1, 8'h01, "R8 resumed");
    rd_chk(2'd2, 8'h22, "R8 resumed data");

    cur_req = "R6";
    send_frame(8'h33, 0, 1, 0, 0, 0, 1, 1);
    rd_chk(2'd1, 8'h03, "R6 overrun");
    rd_chk(2'd2, 8'h22, "R6 data kept");
    wr(2'd1, 8'h00);

    cur_req = "R4";
    wr(2'd0, 8'h0D);
    send_frame(8'h0F, 0, 1, 1, 0, 0, 1, 1);
    rd_chk(2'd1, 8'h01, "R4 odd ok");
    wr(2'd1, 8'h00);
    send_frame(8'h0E, 0, 1, 1, 0, 1, 1, 1);
    rd_chk(2'd1, 8'h08, "R4 odd bad");
    wr(2'd1, 8'h00);

    cur_req = "R5";
    wr(2'd0, 8'h01);
    send_frame(8'h44, 0, 0, 0, 0, 0, 0, 1);
    rd_chk(2'd1, 8'h04, "R5 framing");
    rd_chk(2'd2, 8'h44, "R5 data stored");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h11);
    send_frame(8'h55, 0, 0, 0, 1, 0, 1, 0);
    rd_chk(2'd1, 8'h01, "R5 second stop unchecked");
    rd_chk(2'd2, 8'h55, "R5 two-stop data");
    wr(2'd1, 8'h00);
    send_frame(8'h66, 0, 0, 0, 1, 0, 0, 1);
    rd_chk(2'd1, 8'h04, "R5 first stop checked");
    wr(2'd1, 8'h00);

    cur_req = "R11";
    wr(2'd0, 8'h01);
    fork
      send_frame(8'h77, 0, 0, 0, 0, 0, 1, 1);
      begin
        repeat (60) @(negedge clk);
        wr(2'd0, 8'h07);
      end
    join
    rd_chk(2'd1, 8'h01, "R11 format latched");
    rd_chk(2'd2, 8'h77, "R11 data");
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h01);

    cur_req = "R12";
    fork
      send_frame(8'h12, 0, 0, 0, 0, 0, 1, 1);
      begin
        @(negedge clk);
        while (cyc < last_fin - 1) @(negedge clk);
        wr(2'd1, 8'h00);
      end
    join
    rd_chk(2'd1, 8'h01, "R12 set wins over clear");
    fork
      send_frame(8'h34, 0, 0, 0, 0, 0, 1, 1);
      begin
        @(negedge clk);
        while (cyc < last_fin - 1) @(negedge clk);
        wr(2'd1, 8'h00);
      end
    join
    rd_chk(2'd1, 8'h02, "R12 overrun on pre-write full");
    rd_chk(2'd2, 8'h12, "R12 data kept");

    cur_req = "R10";
    chk("R10 irq_err enabled", {7'b0, irq_err}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R10 irq_err masked", {7'b0, irq_err}, 8'h00);
    wr(2'd0, 8'h01);
    chk("R10 irq_err re-enabled", {7'b0, irq_err}, 8'h01);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule